// File: doc/BRIEF.md
# Timer Match Trigger Generator

The block watches the value of a free-running timer counter and produces a trigger pulse when an enabled match condition occurs. There are six compare channels. Each one matches when the counter equals that channel's compare value. A seventh condition, the initialization match, occurs when the counter equals the initial count value. Each condition has its own enable bit in one 32-bit control and status register.

Every channel match also sets a sticky flag in the same register. Software clears the flag with a two-step handshake. It first reads the register while the flag is set, which arms the clear. It then writes a zero to the flag bit. A channel match that arrives between the read and the write cancels the handshake, so the flag stays set after that write. Downstream logic, such as a converter start input, uses the pulse output. The counter itself is not part of the block.

Top module: `tmr_trig_gen`

## Requirements
- R1: Channel k (0 to 5) matches when `cnt_i` equals its compare slice `cmp_val_i[k*CNT_W +: CNT_W]`. The match counts only while the enable bit of channel k is 1. The enable bits are: channel 0 at bit 4, channel 1 at bit 5, channel 2 at bit 2, channel 3 at bit 1, channel 4 at bit 0 and channel 5 at bit 3.
- R2: The initialization match occurs when `cnt_i` equals `init_val_i`, and counts only while bit 6 is 1.
- R3: `trig_o` is high in the cycle after any enabled channel match or initialization match is present. It is the OR of all of those conditions, and it is low otherwise.
- R4: An enabled channel match sets the flag (bit 7) at the same clock edge that raises `trig_o`. An initialization match alone does not set the flag.
- R5: A cycle with `rd_i` high while the flag is set arms the clear. A later cycle with `wr_i` high and `wdata_i[7]` = 0 then clears the flag and disarms the handshake.
- R6: Writing 1 to bit 7 never sets the flag and never clears it.
- R7: A channel match after the arming read cancels the handshake. The flag stays set after the following write of 0 to bit 7.
- R8: When a channel match and a valid clearing write fall in the same cycle, the flag stays set.
- R9: A read while the flag is clear does not arm the clear. A write of 0 that follows a later setting of the flag, with no read in between, leaves the flag set.
- R10: Bits 6 to 0 take `wdata_i[6:0]` on every write. Bits 31 to 8 read as 0 and ignore writes. All bits are 0 after reset.
- R11: `rdata_o` shows the current register contents in every cycle, independent of `rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Current timer counter value |
| cmp_val_i | input | 6*CNT_W | Compare values; channel k is at slice k*CNT_W |
| init_val_i | input | CNT_W | Initial count value |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data |
| trig_o | output | 1 | Trigger pulse |

## Verification
The counter is swept across all compare values in several ways:
- With a single channel enabled, the sweep shows whether the match is tied to the right compare slice and the right enable bit.
- With only the initialization enable set, it separates the pulse path from the flag path.
- With every enable set, it confirms that the OR is formed over all conditions.

Clear sequences are tried in these orders:
- read, then write zero;
- read, match, then write zero;
- match and write zero in the same cycle;
- read while clear, match, then write zero.

Each of these orders should give a different final flag value if the arming or the priority logic is wrong.

// File: rtl/tmr_trig_pkg.sv
package tmr_trig_pkg;
  localparam int NUM_CH      = 6;
  localparam int REG_W       = 32;
  localparam int FLAG_BIT    = 7;
  localparam int INIT_EN_BIT = 6;
  localparam int CTL_W       = INIT_EN_BIT + 1;

  // register bit that holds the enable of channel ch
  function automatic int en_bit(input int ch);
    case (ch)
      0:       return 4;
      1:       return 5;
      2:       return 2;
      3:       return 1;
      4:       return 0;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/tmr_match_unit.sv
module tmr_match_unit #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 6
) (
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [NUM_CH*CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0]        init_val_i,
  input  logic [NUM_CH-1:0]       ch_en_i,
  input  logic                    init_en_i,
  output logic                    ch_hit_o,
  output logic                    init_hit_o
);
  logic [NUM_CH-1:0] eq;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    assign eq[g] = ch_en_i[g] && (cnt_i == cmp_i[g*CNT_W +: CNT_W]);
  end

  assign ch_hit_o   = |eq;
  assign init_hit_o = init_en_i && (cnt_i == init_val_i);
endmodule

// File: rtl/tmr_trig_csr.sv
module tmr_trig_csr
  import tmr_trig_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ch_hit_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NUM_CH-1:0] ch_en_o,
  output logic              init_en_o,
  output logic [REG_W-1:0]  rdata_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             flag_q;
  logic             arm_q;
  logic             clr_req;

  assign clr_req = wr_i && !wdata_i[FLAG_BIT] && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (wr_i) ctl_q <= wdata_i[CTL_W-1:0];
      // set wins over clear
      if (ch_hit_i)     flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      // new trigger restarts the handshake
      if (ch_hit_i || clr_req) arm_q <= 1'b0;
      else if (rd_i && flag_q) arm_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_en
    localparam int B = en_bit(g);
    assign ch_en_o[g] = ctl_q[B];
  end

  assign init_en_o = ctl_q[INIT_EN_BIT];

  always_comb begin
    rdata_o              = '0;
    rdata_o[CTL_W-1:0]   = ctl_q;
    rdata_o[FLAG_BIT]    = flag_q;
  end
endmodule

// File: rtl/tmr_trig_gen.sv
module tmr_trig_gen
  import tmr_trig_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [NUM_CH*CNT_W-1:0] cmp_val_i,
  input  logic [CNT_W-1:0]        init_val_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  output logic                    trig_o
);
  logic [NUM_CH-1:0] ch_en;
  logic              init_en;
  logic              ch_hit;
  logic              init_hit;
  logic              trig_q;

  tmr_match_unit #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_match (
    .cnt_i      (cnt_i),
    .cmp_i      (cmp_val_i),
    .init_val_i (init_val_i),
    .ch_en_i    (ch_en),
    .init_en_i  (init_en),
    .ch_hit_o   (ch_hit),
    .init_hit_o (init_hit)
  );

  tmr_trig_csr u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ch_hit_i  (ch_hit),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .ch_en_o   (ch_en),
    .init_en_o (init_en),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= ch_hit || init_hit;
  end

  assign trig_o = trig_q;
endmodule

// File: rtl/tmr_trig_gen_chk.sv
module tmr_trig_gen_chk
  import tmr_trig_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ch_hit,
  input logic             init_hit,
  input logic             wr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] rdata_o,
  input logic             trig_o
);
  assert_trig_after_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_hit || init_hit) |=> trig_o);
  assert_no_trig_without_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ch_hit || init_hit) |=> !trig_o);
  assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_hit |=> rdata_o[FLAG_BIT]);
  assert_set_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_hit && wr_i && !wdata_i[FLAG_BIT]) |=> rdata_o[FLAG_BIT]);
  assert_write_one_inert_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[FLAG_BIT] && !ch_hit) |=> $stable(rdata_o[FLAG_BIT]));
  assert_clear_needs_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdata_o[FLAG_BIT]) |-> $past(wr_i && !wdata_i[FLAG_BIT]));
  assert_reserved_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:FLAG_BIT+1] == '0);
endmodule

bind tmr_trig_gen tmr_trig_gen_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ch_hit   (ch_hit),
  .init_hit (init_hit),
  .wr_i     (wr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .trig_o   (trig_o)
);

// File: tb/tmr_trig_gen_test.sv
`timescale 1ns/1ps
module tmr_trig_gen_test;
  localparam int CW = 16;
  localparam int NC = 6;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [CW-1:0]  cnt = '0;
  logic [NC*CW-1:0] cmp;
  logic [CW-1:0]  init_val = 16'd5;
  logic           rd = 1'b0, wr = 1'b0;
  logic [31:0]    wdata = '0;
  logic [31:0]    rdata_o;
  logic           trig_o;

  always #4 clk = ~clk;

  tmr_trig_gen #(.CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_i(cnt), .cmp_val_i(cmp),
    .init_val_i(init_val), .rd_i(rd), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata_o), .trig_o(trig_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int bmap[NC] = '{4, 5, 2, 1, 0, 3};
  int cval[NC] = '{10, 20, 30, 40, 50, 60};

  // reference model state
  bit [7:0] m_reg = '0;
  bit       m_arm = 1'b0;
  bit       m_trig = 1'b0;

  initial for (int i = 0; i < NC; i++) cmp[i*CW +: CW] = cval[i][CW-1:0];

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: drive, compare current outputs, advance model
  task automatic step(input int c, input bit r, input bit w, input logic [31:0] d, input string tag);
    bit ch, ini;
    cnt = c[CW-1:0]; rd = r; wr = w; wdata = d;
    #1;
    check(rdata_o, {24'h0, m_reg}, {tag, " rdata (R11)"});
    check({31'h0, trig_o}, {31'h0, m_trig}, {tag, " trig (R3)"});
    ch = 1'b0;
    for (int i = 0; i < NC; i++) if (m_reg[bmap[i]] && c == cval[i]) ch = 1'b1;
    ini = m_reg[6] && (c == 5);
    @(posedge clk);
    m_trig = ch || ini;
    if (ch) begin
      m_reg[7] = 1'b1; m_arm = 1'b0;
    end else if (w && !d[7] && m_arm) begin
      m_reg[7] = 1'b0; m_arm = 1'b0;
    end else if (r && m_reg[7]) m_arm = 1'b1;
    if (w) m_reg[6:0] = d[6:0];
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(1000, 1'b0, 1'b0, 32'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdata_o, 32'h0, "R10 reset value");
    check({31'h0, trig_o}, 32'h0, "R10 reset trig");
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 R4: channel 0 only (bit 4)
    step(0, 0, 1, 32'h10, "R1 enable ch0");
    for (int c = 0; c < 70; c++) step(c, 0, 0, 32'h0, "R1 sweep ch0");
    check(rdata_o[7], 1'b1, "R4 flag after ch0 match");

    // R5 read then write zero clears
    step(1000, 1, 0, 32'h0, "R5 arm read");
    step(1000, 0, 1, 32'h10, "R5 clear write");
    idle("R5");
    check(rdata_o[7], 1'b0, "R5 flag cleared");

    // R6 write one while clear
    step(1000, 0, 1, 32'h90, "R6 write one");
    idle("R6");
    check(rdata_o[7], 1'b0, "R6 flag stays clear");

    // R2 R4: init only, flag must stay clear
    step(1000, 0, 1, 32'h40, "R2 enable init");
    for (int c = 0; c < 70; c++) step(c, 0, 0, 32'h0, "R2 sweep init");
    check(rdata_o[7], 1'b0, "R4 init does not set flag");

    // R7: ch2 (bit 2) set, read, match, write zero
    step(1000, 0, 1, 32'h04, "R7 enable ch2");
    step(30, 0, 0, 32'h0, "R7 set");
    step(1000, 1, 0, 32'h0, "R7 arm");
    step(30, 0, 0, 32'h0, "R7 new match");
    step(1000, 0, 1, 32'h04, "R7 write zero");
    idle("R7");
    check(rdata_o[7], 1'b1, "R7 flag kept");
    // R6 write one while set
    step(1000, 1, 0, 32'h0, "R6 arm");
    step(1000, 0, 1, 32'h84, "R6 write one armed");
    idle("R6");
    check(rdata_o[7], 1'b1, "R6 flag stays set");

    // R8: match in same cycle as clearing write (ch5, bit 3)
    step(1000, 0, 1, 32'h0C, "R8 enable ch5");
    step(1000, 1, 0, 32'h0, "R8 arm");
    step(60, 0, 1, 32'h0C, "R8 same cycle");
    idle("R8");
    check(rdata_o[7], 1'b1, "R8 set wins");
    step(1000, 1, 0, 32'h0, "R8 rearm");
    step(1000, 0, 1, 32'h0C, "R8 clear");
    idle("R8");
    check(rdata_o[7], 1'b0, "R5 clear after rearm");

    // R9: read while clear, then set, write zero without read
    step(1000, 1, 0, 32'h0, "R9 read clear");
    step(40, 0, 1, 32'h0E, "R9 enable ch3 (bit 1)");
    step(40, 0, 0, 32'h0, "R9 match ch3");
    step(1000, 0, 1, 32'h0E, "R9 write zero");
    idle("R9");
    check(rdata_o[7], 1'b1, "R9 not armed");

    // R10: reserved bits, then R3 all enables OR
    step(1000, 0, 1, 32'hFFFF_FFFF, "R10 write all ones");
    idle("R10");
    check(rdata_o, 32'h0000_00FF, "R10 reserved read zero");
    for (int c = 0; c < 70; c++) step(c, 0, 0, 32'h0, "R3 sweep all");
    for (int c = 70; c > 0; c -= 5) step(c, (c % 10) == 0, 0, 32'h0, "R1 down sweep");
    step(1000, 0, 1, 32'h0, "R10 clear enables");
    for (int c = 0; c < 70; c++) step(c, 0, 0, 32'h0, "R1 disabled sweep");
    check({31'h0, trig_o}, 32'h0, "R1 no trigger when disabled");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule